// File: doc/BRIEF.md
# Interrupt Exception Frame Sequencer

This block carries out the stacking part of interrupt exception processing for a 32-bit processor core. The core hands it an accepted interrupt, its priority level, the vector number returned by the acknowledging peripheral, and a flag that marks the peripheral's vector as never programmed. Along with these come the live status register (SR), the program counter at which execution should resume, both supervisor stack pointers and a flag that marks a coprocessor instruction as partly executed. The block then writes the exception frame one 16-bit word per cycle. It fetches the handler address from the vector table and presents the SR, PC and stack pointers the core must adopt.

When the master-stack bit of the incoming SR is set, the primary frame goes on the master stack. A second, throwaway frame with format code 1 then goes on the interrupt stack. Its SR copy has the supervisor bit forced on. The primary frame uses format 0, or format 9 when a coprocessor instruction was in flight. Format 9 also saves a 32-bit word of coprocessor context.

Top module: `irq_frame_seq`

## Requirements
- R1: While reset is held and after it is released, with no request: wr_valid_o, rd_valid_o and done_o are 0, and new_pc_o and new_sr_o are 0.
- R2: The vector offset is the vector number times 4. It sits in bits 11:0 of the format word, whose bits 15:12 hold the format code. The handler address is read at vbr_i plus that offset.
- R3: When req_uninit_i is 1 at acceptance, vector number 15 is used whatever req_vector_i holds. The offset is then 0x03C.
- R4: Frame words are written one per cycle, starting the cycle after acceptance. Each goes at the active stack pointer minus 2, and that pointer moves down by 2 with each write. The order is format word, PC bits 15:0, PC bits 31:16, then SR copy.
- R5: The primary frame uses format 0 when cop_busy_i is 0. When cop_busy_i is 1 it uses format 9, and cop_info_i bits 31:16 and then bits 15:0 are written before its format word.
- R6: When SR bit 12 (M) is 1, the primary frame goes on the master stack and holds the SR unchanged. It is followed at once by a format-1 frame on the interrupt stack, with the same PC and offset and an SR copy with bit 13 (S) set. When M is 0, only the primary frame is written, on the interrupt stack.
- R7: When done_o is high, new_sr_o equals the incoming SR with bit 13 set, bit 12 cleared and bits 10:8 equal to the accepted level. All other bits are unchanged.
- R8: The vector read (rd_valid_o) is issued in the cycle after the last frame write. rd_data_i is taken the following cycle. done_o is high for exactly one cycle afterwards, with new_pc_o equal to the read data.
- R9: A request presented while a sequence is in progress is ignored. It causes no write, no read and no change to the values being written.
- R10: When done_o is high, new_msp_o and new_isp_o equal the input stack pointers less 2 bytes per word written on each stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Accepted interrupt request, one-cycle strobe |
| req_level_i | input | 3 | Priority level of the accepted interrupt |
| req_vector_i | input | VEC_W | Vector number from the peripheral |
| req_uninit_i | input | 1 | Peripheral vector was never programmed |
| cur_sr_i | input | 16 | Status register at acceptance |
| resume_pc_i | input | ADDR_W | Address of the next instruction |
| msp_i | input | ADDR_W | Master stack pointer |
| isp_i | input | ADDR_W | Interrupt stack pointer |
| cop_busy_i | input | 1 | A coprocessor instruction was mid-execution |
| cop_info_i | input | ADDR_W | Coprocessor context saved in a format-9 frame |
| vbr_i | input | ADDR_W | Vector table base address |
| wr_valid_o | output | 1 | Frame word write strobe |
| wr_addr_o | output | ADDR_W | Byte address of the word written |
| wr_data_o | output | 16 | Frame word |
| rd_valid_o | output | 1 | Vector table read strobe |
| rd_addr_o | output | ADDR_W | Vector table entry address |
| rd_data_i | input | ADDR_W | Vector table entry, valid one cycle after the strobe |
| done_o | output | 1 | One-cycle pulse: new PC, SR and pointers are valid |
| new_sr_o | output | 16 | Status register to adopt |
| new_pc_o | output | ADDR_W | Handler address |
| new_msp_o | output | ADDR_W | Master stack pointer after stacking |
| new_isp_o | output | ADDR_W | Interrupt stack pointer after stacking |

## Verification
The bench drives requests with M clear and M set, each with and without a coprocessor instruction in flight. This yields frames of 4, 6, 8 and 10 words. Comparing these separates stack selection, format choice and the throwaway frame's forced S bit from the unchanged master-stack copy. One case uses an SR with S clear and M set, so that a wrong S in either copy shows up. Vector numbers 0x40, 0xFF and an uninitialized vector carrying a decoy number check the offset arithmetic and the substitution of vector 15. A second request injected mid-sequence must leave the word stream, the read address and the single done pulse untouched.

// File: rtl/irq_frame_pkg.sv
package irq_frame_pkg;

  localparam int WORD_W      = 16;
  localparam int OFF_W       = 12;
  localparam int FMT_W       = 4;
  localparam int LVL_W       = 3;
  localparam int SLOT_W      = 3;
  localparam int SR_IPL_LSB  = 8;

  localparam logic [WORD_W-1:0] SR_S_MASK   = 16'h2000;
  localparam logic [WORD_W-1:0] SR_M_MASK   = 16'h1000;
  localparam logic [WORD_W-1:0] SR_IPL_MASK = 16'h0700;

  localparam logic [FMT_W-1:0] FMT_NORMAL = 4'h0;
  localparam logic [FMT_W-1:0] FMT_THROW  = 4'h1;
  localparam logic [FMT_W-1:0] FMT_COP    = 4'h9;

  // frame slots in write order; a short frame starts at SLOT_FMT
  localparam logic [SLOT_W-1:0] SLOT_COP_HI = 3'd0;
  localparam logic [SLOT_W-1:0] SLOT_COP_LO = 3'd1;
  localparam logic [SLOT_W-1:0] SLOT_FMT    = 3'd2;
  localparam logic [SLOT_W-1:0] SLOT_PC_LO  = 3'd3;
  localparam logic [SLOT_W-1:0] SLOT_PC_HI  = 3'd4;
  localparam logic [SLOT_W-1:0] SLOT_SR     = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_FETCH,
    ST_WAIT,
    ST_FIN
  } seq_state_e;

endpackage

// File: rtl/irq_frame_word.sv
module irq_frame_word
  import irq_frame_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [FMT_W-1:0]  fmt_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [WORD_W-1:0] sr_i,
  input  logic [ADDR_W-1:0] info_i,
  output logic [WORD_W-1:0] word_o
);

  always_comb begin
    unique case (slot_i)
      SLOT_COP_HI: word_o = info_i[ADDR_W-1 -: WORD_W];
      SLOT_COP_LO: word_o = info_i[WORD_W-1:0];
      SLOT_FMT:    word_o = {fmt_i, off_i};
      SLOT_PC_LO:  word_o = pc_i[WORD_W-1:0];
      SLOT_PC_HI:  word_o = pc_i[ADDR_W-1 -: WORD_W];
      default:     word_o = sr_i;
    endcase
  end

endmodule

// File: rtl/irq_frame_ctrl.sv
module irq_frame_ctrl
  import irq_frame_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [LVL_W-1:0]  req_level_i,
  input  logic [VEC_W-1:0]  req_vector_i,
  input  logic              req_uninit_i,
  input  logic [WORD_W-1:0] cur_sr_i,
  input  logic [ADDR_W-1:0] resume_pc_i,
  input  logic [ADDR_W-1:0] msp_i,
  input  logic [ADDR_W-1:0] isp_i,
  input  logic              cop_busy_i,
  input  logic [ADDR_W-1:0] cop_info_i,
  input  logic [ADDR_W-1:0] vbr_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [FMT_W-1:0]  fmt_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [WORD_W-1:0] sr_copy_o,
  output logic [ADDR_W-1:0] info_o,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [ADDR_W-1:0] rd_data_i,
  output logic              done_o,
  output logic [WORD_W-1:0] new_sr_o,
  output logic [ADDR_W-1:0] new_pc_o,
  output logic [ADDR_W-1:0] new_msp_o,
  output logic [ADDR_W-1:0] new_isp_o
);

  localparam int OFF_PAD = OFF_W - VEC_W - 2;
  localparam logic [VEC_W-1:0] UNINIT_VEC = VEC_W'(15);
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(WORD_W / 8);

  seq_state_e        state_q, state_d;
  logic [VEC_W-1:0]  vec_q, vec_d;
  logic [WORD_W-1:0] sr_q, sr_d;
  logic [WORD_W-1:0] nsr_q, nsr_d;
  logic [ADDR_W-1:0] rpc_q, rpc_d;
  logic [ADDR_W-1:0] hpc_q, hpc_d;
  logic [ADDR_W-1:0] info_q, info_d;
  logic [ADDR_W-1:0] vbr_q, vbr_d;
  logic [ADDR_W-1:0] msp_q, msp_d;
  logic [ADDR_W-1:0] isp_q, isp_d;
  logic              cop_q, cop_d;
  logic              on_msp_q, on_msp_d;
  logic              second_q, second_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              accept;
  logic              push_en;
  logic [ADDR_W-1:0] sp_cur;
  logic [OFF_W-1:0]  off;

  assign accept  = (state_q == ST_IDLE) && req_valid_i;
  assign push_en = (state_q == ST_PUSH);
  assign sp_cur  = on_msp_q ? msp_q : isp_q;
  assign off     = {{OFF_PAD{1'b0}}, vec_q, 2'b00};

  // next-state process
  always_comb begin
    state_d  = state_q;
    vec_d    = vec_q;
    sr_d     = sr_q;
    nsr_d    = nsr_q;
    rpc_d    = rpc_q;
    hpc_d    = hpc_q;
    info_d   = info_q;
    vbr_d    = vbr_q;
    msp_d    = msp_q;
    isp_d    = isp_q;
    cop_d    = cop_q;
    on_msp_d = on_msp_q;
    second_d = second_q;
    slot_d   = slot_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d  = ST_PUSH;
          vec_d    = req_uninit_i ? UNINIT_VEC : req_vector_i;
          sr_d     = cur_sr_i;
          nsr_d    = (cur_sr_i & ~(SR_S_MASK | SR_M_MASK | SR_IPL_MASK))
                   | SR_S_MASK
                   | (WORD_W'(req_level_i) << SR_IPL_LSB);
          rpc_d    = resume_pc_i;
          info_d   = cop_info_i;
          vbr_d    = vbr_i;
          msp_d    = msp_i;
          isp_d    = isp_i;
          cop_d    = cop_busy_i;
          on_msp_d = (cur_sr_i & SR_M_MASK) != '0;
          second_d = 1'b0;
          slot_d   = cop_busy_i ? SLOT_COP_HI : SLOT_FMT;
        end
      end
      ST_PUSH: begin
        if (on_msp_q) msp_d = msp_q - WORD_BYTES;
        else          isp_d = isp_q - WORD_BYTES;
        if (slot_q == SLOT_SR) begin
          if (on_msp_q) begin
            on_msp_d = 1'b0;
            second_d = 1'b1;
            slot_d   = SLOT_FMT;
          end else begin
            state_d  = ST_FETCH;
          end
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end
      ST_FETCH: state_d = ST_WAIT;
      ST_WAIT: begin
        hpc_d   = rd_data_i;
        state_d = ST_FIN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      vec_q    <= '0;
      sr_q     <= '0;
      nsr_q    <= '0;
      rpc_q    <= '0;
      hpc_q    <= '0;
      info_q   <= '0;
      vbr_q    <= '0;
      msp_q    <= '0;
      isp_q    <= '0;
      cop_q    <= 1'b0;
      on_msp_q <= 1'b0;
      second_q <= 1'b0;
      slot_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        vec_q  <= vec_d;
        sr_q   <= sr_d;
        nsr_q  <= nsr_d;
        rpc_q  <= rpc_d;
        info_q <= info_d;
        vbr_q  <= vbr_d;
        cop_q  <= cop_d;
      end
      if (accept || push_en) begin
        msp_q    <= msp_d;
        isp_q    <= isp_d;
        on_msp_q <= on_msp_d;
        second_q <= second_d;
        slot_q   <= slot_d;
      end
      if (state_q == ST_WAIT) hpc_q <= hpc_d;
    end
  end

  assign wr_valid_o = push_en;
  assign wr_addr_o  = sp_cur - WORD_BYTES;
  assign slot_o     = slot_q;
  assign fmt_o      = second_q ? FMT_THROW : (cop_q ? FMT_COP : FMT_NORMAL);
  assign off_o      = off;
  assign pc_o       = rpc_q;
  assign sr_copy_o  = second_q ? (sr_q | SR_S_MASK) : sr_q;
  assign info_o     = info_q;
  assign rd_valid_o = (state_q == ST_FETCH);
  assign rd_addr_o  = vbr_q + ADDR_W'(off);
  assign done_o     = (state_q == ST_FIN);
  assign new_sr_o   = nsr_q;
  assign new_pc_o   = hpc_q;
  assign new_msp_o  = msp_q;
  assign new_isp_o  = isp_q;

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && $past(wr_valid_o) && (on_msp_q == $past(on_msp_q))
      |-> wr_addr_o == $past(wr_addr_o) - WORD_BYTES); // R4

  AST_UNINIT_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) && req_valid_i && req_uninit_i
      |=> vec_q == UNINIT_VEC); // R3

  AST_DONE_SR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((new_sr_o & SR_S_MASK) != '0) && ((new_sr_o & SR_M_MASK) == '0)); // R7

  AST_RD_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(wr_valid_o)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) && req_valid_i |=> $stable(vec_q) && $stable(sr_q)); // R9

  AST_THROW_FMT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && $fell(on_msp_q) |-> fmt_o == FMT_THROW); // R6

endmodule

// File: rtl/irq_frame_seq.sv
module irq_frame_seq
  import irq_frame_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_level_i,
  input  logic [VEC_W-1:0]  req_vector_i,
  input  logic              req_uninit_i,
  input  logic [15:0]       cur_sr_i,
  input  logic [ADDR_W-1:0] resume_pc_i,
  input  logic [ADDR_W-1:0] msp_i,
  input  logic [ADDR_W-1:0] isp_i,
  input  logic              cop_busy_i,
  input  logic [ADDR_W-1:0] cop_info_i,
  input  logic [ADDR_W-1:0] vbr_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [15:0]       wr_data_o,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [ADDR_W-1:0] rd_data_i,
  output logic              done_o,
  output logic [15:0]       new_sr_o,
  output logic [ADDR_W-1:0] new_pc_o,
  output logic [ADDR_W-1:0] new_msp_o,
  output logic [ADDR_W-1:0] new_isp_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic [SLOT_W-1:0] slot;
  logic [FMT_W-1:0]  fmt;
  logic [OFF_W-1:0]  off;
  logic [ADDR_W-1:0] pc;
  logic [WORD_W-1:0] sr_copy;
  logic [ADDR_W-1:0] info;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  irq_frame_ctrl #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid_i),
    .req_level_i  (req_level_i),
    .req_vector_i (req_vector_i),
    .req_uninit_i (req_uninit_i),
    .cur_sr_i     (cur_sr_i),
    .resume_pc_i  (resume_pc_i),
    .msp_i        (msp_i),
    .isp_i        (isp_i),
    .cop_busy_i   (cop_busy_i),
    .cop_info_i   (cop_info_i),
    .vbr_i        (vbr_i),
    .wr_valid_o   (wr_valid_o),
    .wr_addr_o    (wr_addr_o),
    .slot_o       (slot),
    .fmt_o        (fmt),
    .off_o        (off),
    .pc_o         (pc),
    .sr_copy_o    (sr_copy),
    .info_o       (info),
    .rd_valid_o   (rd_valid_o),
    .rd_addr_o    (rd_addr_o),
    .rd_data_i    (rd_data_i),
    .done_o       (done_o),
    .new_sr_o     (new_sr_o),
    .new_pc_o     (new_pc_o),
    .new_msp_o    (new_msp_o),
    .new_isp_o    (new_isp_o)
  );

  irq_frame_word #(.ADDR_W(ADDR_W)) u_word (
    .slot_i (slot),
    .fmt_i  (fmt),
    .off_i  (off),
    .pc_i   (pc),
    .sr_i   (sr_copy),
    .info_i (info),
    .word_o (wr_data_o)
  );

endmodule

// File: tb/irq_frame_seq_tb.sv
module irq_frame_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_level = '0;
  logic [7:0]  req_vector = '0;
  logic        req_uninit = 1'b0;
  logic [15:0] cur_sr = '0;
  logic [31:0] resume_pc = '0, msp = '0, isp = '0, cop_info = '0, vbr = '0;
  logic        cop_busy = 1'b0;
  logic        wr_valid, rd_valid, done;
  logic [31:0] wr_addr, rd_addr, new_pc, new_msp, new_isp;
  logic [31:0] rd_data = '0;
  logic [15:0] wr_data, new_sr;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] exp_addr [16];
  logic [15:0] exp_data [16];
  int          exp_n;
  logic [31:0] got_addr [16];
  logic [15:0] got_data [16];
  int          got_n;
  logic [31:0] got_rd_addr, got_pc, got_msp, got_isp;
  logic [15:0] got_sr;
  int          rd_cnt, done_cnt;
  bit          done_twice;

  always #2.5 clk = ~clk;

  irq_frame_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_level_i(req_level),
    .req_vector_i(req_vector), .req_uninit_i(req_uninit), .cur_sr_i(cur_sr),
    .resume_pc_i(resume_pc), .msp_i(msp), .isp_i(isp), .cop_busy_i(cop_busy),
    .cop_info_i(cop_info), .vbr_i(vbr), .wr_valid_o(wr_valid), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .rd_valid_o(rd_valid), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .done_o(done), .new_sr_o(new_sr), .new_pc_o(new_pc), .new_msp_o(new_msp),
    .new_isp_o(new_isp)
  );

  function automatic logic [31:0] handler_of(input logic [31:0] a);
    return 32'h00F0_0000 ^ (a << 3) ^ 32'h0000_5A5A;
  endfunction

  // vector table model: one cycle read latency
  always @(posedge clk) if (rd_valid) rd_data <= handler_of(rd_addr);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic add_word(inout logic [31:0] sp, input logic [15:0] d);
    sp = sp - 32'd2;
    exp_addr[exp_n] = sp;
    exp_data[exp_n] = d;
    exp_n++;
  endtask

  task automatic add_frame(inout logic [31:0] sp, input logic [3:0] fmt,
                           input logic [11:0] off, input logic [31:0] pc,
                           input logic [15:0] src, input bit with_cop,
                           input logic [31:0] info);
    if (with_cop) begin
      add_word(sp, info[31:16]);
      add_word(sp, info[15:0]);
    end
    add_word(sp, {fmt, off});
    add_word(sp, pc[15:0]);
    add_word(sp, pc[31:16]);
    add_word(sp, src);
  endtask

  task automatic run_case(input logic [2:0] lvl, input logic [7:0] vec, input bit uninit,
                          input logic [15:0] sr, input logic [31:0] pc,
                          input logic [31:0] m_sp, input logic [31:0] i_sp,
                          input bit cop, input logic [31:0] info,
                          input logic [31:0] base, input bit inject);
    logic [7:0]  v;
    logic [11:0] off;
    logic [31:0] spm, spi;
    logic [15:0] exp_sr;
    bit          prev_done;
    v   = uninit ? 8'd15 : vec;
    off = {2'b00, v, 2'b00};
    spm = m_sp;
    spi = i_sp;
    exp_n = 0;
    if (sr[12]) begin
      add_frame(spm, cop ? 4'h9 : 4'h0, off, pc, sr, cop, info);
      add_frame(spi, 4'h1, off, pc, sr | 16'h2000, 1'b0, 32'h0);
    end else begin
      add_frame(spi, cop ? 4'h9 : 4'h0, off, pc, sr, cop, info);
    end
    exp_sr = (sr & ~16'h3700) | 16'h2000 | ({13'b0, lvl} << 8);

    got_n = 0; rd_cnt = 0; done_cnt = 0; done_twice = 0; prev_done = 0;
    got_rd_addr = '0;
    @(negedge clk);
    req_level = lvl; req_vector = vec; req_uninit = uninit; cur_sr = sr;
    resume_pc = pc; msp = m_sp; isp = i_sp; cop_busy = cop; cop_info = info; vbr = base;
    req_valid = 1'b1;
    for (int cyc = 0; cyc < 30; cyc++) begin
      @(negedge clk);
      if (wr_valid && got_n < 16) begin
        got_addr[got_n] = wr_addr;
        got_data[got_n] = wr_data;
      end
      if (wr_valid) got_n++;
      if (rd_valid) begin rd_cnt++; got_rd_addr = rd_addr; end
      if (done) begin
        done_cnt++;
        if (prev_done) done_twice = 1;
        got_pc = new_pc; got_sr = new_sr; got_msp = new_msp; got_isp = new_isp;
      end
      prev_done = done;
      req_valid = 1'b0;
      if (inject && cyc == 2) begin
        req_valid = 1'b1; req_vector = 8'h11; req_level = 3'd1;
        cur_sr = 16'h1000; cop_busy = 1'b1; resume_pc = 32'hDEAD_0000;
      end
    end

    chk(got_n == exp_n, "R4", "word count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_addr[i] == exp_addr[i], "R4", "write address", got_addr[i], exp_addr[i]);
      chk(got_data[i] == exp_data[i], "R4", "write data", {16'h0, got_data[i]}, {16'h0, exp_data[i]});
    end
    chk(rd_cnt == 1, "R8", "read count", rd_cnt, 1);
    chk(got_rd_addr == base + {20'h0, off}, "R2", "vector read address",
        got_rd_addr, base + {20'h0, off});
    chk(done_cnt == 1 && !done_twice, "R8", "single done pulse", done_cnt, 1);
    chk(got_pc == handler_of(base + {20'h0, off}), "R8", "new pc",
        got_pc, handler_of(base + {20'h0, off}));
    chk(got_sr == exp_sr, "R7", "new sr", {16'h0, got_sr}, {16'h0, exp_sr});
    chk(got_msp == spm, "R10", "new msp", got_msp, spm);
    chk(got_isp == spi, "R10", "new isp", got_isp, spi);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!wr_valid && !rd_valid && !done, "R1", "strobes in reset",
        {29'h0, wr_valid, rd_valid, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!wr_valid && !rd_valid && !done, "R1", "strobes after reset",
        {29'h0, wr_valid, rd_valid, done}, 0);
    chk(new_pc == 0, "R1", "new pc after reset", new_pc, 0);
    chk(new_sr == 0, "R1", "new sr after reset", {16'h0, new_sr}, 0);
  endtask

  task automatic t_basic;
    run_case(3'd5, 8'h40, 1'b0, 16'h2004, 32'h0001_2346, 32'h0000_8000,
             32'h0000_4000, 1'b0, 32'h0, 32'h0001_0000, 1'b0);
    chk(got_data[0] == 16'h0100, "R2", "format word offset 0x100", {16'h0, got_data[0]}, 32'h0100);
    chk(got_data[0][15:12] == 4'h0, "R5", "format 0 without coprocessor", {28'h0, got_data[0][15:12]}, 0);
    chk(got_addr[0] == 32'h0000_3FFE, "R6", "M clear uses interrupt stack", got_addr[0], 32'h3FFE);
  endtask

  task automatic t_uninit;
    run_case(3'd2, 8'hAA, 1'b1, 16'h2000, 32'h0000_1000, 32'h0000_9000,
             32'h0000_5000, 1'b0, 32'h0, 32'h0000_0400, 1'b0);
    chk(got_data[0][11:0] == 12'h03C, "R3", "uninitialized vector offset",
        {20'h0, got_data[0][11:0]}, 32'h03C);
    chk(got_rd_addr == 32'h0000_043C, "R3", "uninitialized read address", got_rd_addr, 32'h043C);
  endtask

  task automatic t_cop;
    run_case(3'd7, 8'hFF, 1'b0, 16'h2300, 32'h00AB_CDEE, 32'h0000_8800,
             32'h0000_4400, 1'b1, 32'hCAFE_BEEF, 32'h0002_0000, 1'b0);
    chk(got_data[0] == 16'hCAFE && got_data[1] == 16'hBEEF, "R5", "coprocessor words first",
        {got_data[0], got_data[1]}, 32'hCAFE_BEEF);
    chk(got_data[2] == 16'h93FC, "R5", "format 9 word, offset 0x3FC", {16'h0, got_data[2]}, 32'h93FC);
  endtask

  task automatic t_master;
    run_case(3'd3, 8'h19, 1'b0, 16'h1700, 32'h0004_0002, 32'h0000_A000,
             32'h0000_6000, 1'b0, 32'h0, 32'h0000_0000, 1'b0);
    chk(got_addr[0] == 32'h0000_9FFE, "R6", "primary frame on master stack", got_addr[0], 32'h9FFE);
    chk(got_data[3] == 16'h1700, "R6", "master copy keeps S", {16'h0, got_data[3]}, 32'h1700);
    chk(got_addr[4] == 32'h0000_5FFE, "R6", "throwaway on interrupt stack", got_addr[4], 32'h5FFE);
    chk(got_data[4][15:12] == 4'h1, "R6", "throwaway format 1", {28'h0, got_data[4][15:12]}, 1);
    chk(got_data[7] == 16'h3700, "R6", "throwaway copy has S set", {16'h0, got_data[7]}, 32'h3700);
  endtask

  task automatic t_master_cop;
    run_case(3'd6, 8'h64, 1'b0, 16'h3010, 32'h1234_5678, 32'h0000_C000,
             32'h0000_7000, 1'b1, 32'h0BAD_F00D, 32'h0000_0800, 1'b0);
    chk(got_data[2][15:12] == 4'h9 && got_data[6][15:12] == 4'h1, "R6",
        "format 9 then format 1", {got_data[2], got_data[6]}, 32'h9190_1190);
  endtask

  task automatic t_busy;
    run_case(3'd4, 8'h30, 1'b0, 16'h2000, 32'h0000_2222, 32'h0000_B000,
             32'h0000_3000, 1'b0, 32'h0, 32'h0000_1000, 1'b1);
    chk(got_n == 4, "R9", "request while busy adds no words", got_n, 4);
    chk(got_data[0] == 16'h00C0, "R9", "format word unchanged", {16'h0, got_data[0]}, 32'h00C0);
    chk(got_data[1] == 16'h2222, "R9", "saved pc unchanged", {16'h0, got_data[1]}, 32'h2222);
    chk(rd_cnt == 1, "R9", "request while busy adds no read", rd_cnt, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_uninit();
    t_cop();
    t_master();
    t_master_cop();
    t_busy();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule